// File: doc/BRIEF.md
# Display Adapter Register Window Decoder

This block sits behind a 4 KiB memory-mapped aperture of a display adapter. It turns each host access into traffic for one of three register banks. The first bank is the classic VGA I/O-port range, relocated into memory space and driven one byte per cycle. The second is a small file of 16-bit mode-setting registers, reached through an index strobe followed by a data strobe. The third is an optional bank of 32-bit registers. That bank reports its own size and holds the flag that sets the framebuffer byte order.

The host raises `req_i` with the address, access size and write data, and holds them until `ready_o` is high. Single-byte legacy accesses and all accesses that hit no bank, or the extended bank, finish in the cycle they are presented. Wider legacy accesses take one cycle per byte. Mode-register accesses take two cycles: index, then data. The parameter `EXT_EN` decides whether the extended bank exists, and it also sets the revision value shown to the host.

Top module: `disp_mmio_window`

## Requirements
- R1: An access whose address is outside 0x400..0x41F, 0x500..0x515 and (when enabled) 0x600..0x607 completes in its first cycle. A read returns 0, a write changes nothing, and no downstream strobe fires.
- R2: A 1-byte access (size code 0) to offset 0x400+n strobes legacy port 0x3C0+n once, in a single cycle. A write drives wdata bits 7:0 to the port, and a read returns the port byte in rdata bits 7:0 with the upper bits 0.
- R3: A 2-byte write (size code 1) to offset 0x400+n takes two cycles, with ready low in the first. Bits 7:0 go to port 0x3C0+n in the first cycle, then bits 15:8 go to port 0x3C0+n+1.
- R4: A 2-byte legacy read returns port 0x3C0+n in bits 7:0 and port 0x3C0+n+1 in bits 15:8, with bits 31:16 at 0.
- R5: A 4-byte legacy access (size code 2 or 3) takes four cycles and touches ports n..n+3 in ascending order, one byte lane per cycle, lowest lane first.
- R6: An access to offset 0x500+k strobes register index k>>1 in its first cycle. In the second cycle it strobes data: a write drives wdata bits 15:0, a read returns the register in bits 15:0. Ready is high only in the second cycle.
- R7: A 4-byte read of 0x600 returns 8. A 4-byte read of any other offset in 0x600..0x607 except 0x604 returns 0.
- R8: A 4-byte read of 0x604 returns 0xBEBEBEBE when the byte-order flag is big-endian and 0x1E1E1E1E when it is little-endian. The flag comes out of reset little-endian (big_endian_o = 0).
- R9: A 4-byte write of 0xBEBEBEBE to 0x604 sets the flag to big-endian, and a write of 0x1E1E1E1E sets it to little-endian. Any other value leaves the flag unchanged.
- R10: A 1- or 2-byte access to the extended bank reads 0 and does not change the flag on a write.
- R11: rev_id_o is 2 when EXT_EN is set and BASE_REV otherwise. With EXT_EN clear, offsets 0x600..0x607 behave as in R1.
- R12: No more than one downstream strobe (legacy, mode index, mode data) is high in any cycle. Back-to-back accesses with no idle cycle between them run in order without merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wdata_i | input | 32 | Write data, byte lanes little-endian |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | 32 | Read data, valid with ready_o |
| leg_stb_o | output | 1 | Legacy port strobe |
| leg_we_o | output | 1 | Legacy port write |
| leg_port_o | output | 10 | Legacy port number |
| leg_wdata_o | output | 8 | Legacy port write byte |
| leg_rdata_i | input | 8 | Legacy port read byte for leg_port_o |
| mode_idx_stb_o | output | 1 | Mode-register index strobe |
| mode_idx_o | output | 4 | Mode-register index |
| mode_dat_stb_o | output | 1 | Mode-register data strobe |
| mode_dat_we_o | output | 1 | Mode-register data write |
| mode_wdata_o | output | 16 | Mode-register write data |
| mode_rdata_i | input | 16 | Mode-register read data for the latched index |
| big_endian_o | output | 1 | Framebuffer byte-order flag |
| rev_id_o | output | 8 | Revision value for the host |

## Verification
The final beat of a multi-cycle legacy or mode access can coincide with the next request: in the cycle after `ready_o`, the host presents a fresh access with no idle cycle in between. The bench provokes this by chaining two split 16-bit legacy writes and a mode write back to back. It judges the result from a log of port strobes and data bytes, which must show four ordered, distinct byte writes and then an index-then-data pair. It also counts every cycle in which more than one strobe is high.

// File: rtl/disp_mmio_pkg.sv
package disp_mmio_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PORT_W  = 10;
  localparam int unsigned MIDX_W  = 4;
  localparam int unsigned MDAT_W  = 16;
  localparam int unsigned LOFF_W  = 5;
  localparam int unsigned EOFF_W  = 3;

  localparam logic [ADDR_W-1:0] LEG_BASE  = 12'h400;
  localparam logic [ADDR_W-1:0] LEG_SPAN  = 12'h020;
  localparam logic [ADDR_W-1:0] MODE_BASE = 12'h500;
  localparam logic [ADDR_W-1:0] MODE_SPAN = 12'h016;
  localparam logic [ADDR_W-1:0] EXT_BASE  = 12'h600;
  localparam logic [ADDR_W-1:0] EXT_SPAN  = 12'h008;

  localparam logic [PORT_W-1:0] LEG_PORT0 = 10'h3C0;
  localparam logic [DATA_W-1:0] ORDER_BIG = 32'hBEBE_BEBE;
  localparam logic [DATA_W-1:0] ORDER_LIT = 32'h1E1E_1E1E;

  typedef enum logic [1:0] {RG_NONE, RG_LEG, RG_MODE, RG_EXT} region_e;
endpackage

// File: rtl/disp_mmio_decode.sv
module disp_mmio_decode
  import disp_mmio_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] off_o
);
  always_comb begin
    region_o = RG_NONE;
    off_o    = '0;
    if (addr_i >= LEG_BASE && addr_i < LEG_BASE + LEG_SPAN) begin
      region_o = RG_LEG;
      off_o    = addr_i - LEG_BASE;
    end else if (addr_i >= MODE_BASE && addr_i < MODE_BASE + MODE_SPAN) begin
      region_o = RG_MODE;
      off_o    = addr_i - MODE_BASE;
    end else if (EXT_EN && addr_i >= EXT_BASE && addr_i < EXT_BASE + EXT_SPAN) begin
      region_o = RG_EXT;
      off_o    = addr_i - EXT_BASE;
    end
  end
endmodule

// File: rtl/disp_mmio_legacy.sv
module disp_mmio_legacy
  import disp_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              we_i,
  input  logic [LOFF_W-1:0] off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [7:0]        port_rdata_i,
  output logic              stb_o,
  output logic              we_o,
  output logic [PORT_W-1:0] port_o,
  output logic [7:0]        port_wdata_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [1:0]        beat_q, last_beat;
  logic [DATA_W-1:0] acc_q;

  always_comb begin
    case (size_i)
      2'd0:    last_beat = 2'd0;
      2'd1:    last_beat = 2'd1;
      default: last_beat = 2'd3;
    endcase
  end

  assign stb_o        = act_i;
  assign we_o         = act_i & we_i;
  assign port_o       = LEG_PORT0 + PORT_W'(off_i) + PORT_W'(beat_q);
  assign port_wdata_o = wdata_i[{beat_q, 3'b000} +: 8];
  assign done_o       = act_i && (beat_q == last_beat);

  // earlier lanes from the accumulator, current lane straight from the port
  always_comb begin
    rdata_o = acc_q;
    rdata_o[{beat_q, 3'b000} +: 8] = port_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      acc_q  <= '0;
    end else if (act_i && !done_o) begin
      beat_q <= beat_q + 2'd1;
      acc_q[{beat_q, 3'b000} +: 8] <= port_rdata_i;
    end else begin
      beat_q <= '0;
      acc_q  <= '0;
    end
  end
endmodule

// File: rtl/disp_mmio_mode.sv
module disp_mmio_mode
  import disp_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              we_i,
  input  logic [LOFF_W-1:0] off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MDAT_W-1:0] dat_rdata_i,
  output logic              idx_stb_o,
  output logic [MIDX_W-1:0] idx_o,
  output logic              dat_stb_o,
  output logic              dat_we_o,
  output logic [MDAT_W-1:0] dat_wdata_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic phase_q;

  assign idx_stb_o   = act_i & ~phase_q;
  assign idx_o       = off_i[LOFF_W-1:1];
  assign dat_stb_o   = act_i & phase_q;
  assign dat_we_o    = dat_stb_o & we_i;
  assign dat_wdata_o = wdata_i[MDAT_W-1:0];
  assign done_o      = dat_stb_o;
  assign rdata_o     = DATA_W'(dat_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= act_i & ~phase_q;
  end
endmodule

// File: rtl/disp_mmio_ext.sv
module disp_mmio_ext
  import disp_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              we_i,
  input  logic [EOFF_W-1:0] off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              big_endian_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic full, hit_size, hit_order;

  assign full      = act_i & size_i[1];
  assign hit_size  = full && (off_i == 3'd0);
  assign hit_order = full && (off_i == 3'd4);

  always_comb begin
    rdata_o = '0;
    if (hit_size)  rdata_o = DATA_W'(EXT_SPAN);
    if (hit_order) rdata_o = big_endian_o ? ORDER_BIG : ORDER_LIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      big_endian_o <= 1'b0;
    end else if (hit_order && we_i) begin
      if (wdata_i == ORDER_BIG)      big_endian_o <= 1'b1;
      else if (wdata_i == ORDER_LIT) big_endian_o <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_mmio_window.sv
module disp_mmio_window
  import disp_mmio_pkg::*;
#(
  parameter bit         EXT_EN   = 1'b1,
  parameter logic [7:0] BASE_REV = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              ready_o,
  output logic [31:0]       rdata_o,
  output logic              leg_stb_o,
  output logic              leg_we_o,
  output logic [9:0]        leg_port_o,
  output logic [7:0]        leg_wdata_o,
  input  logic [7:0]        leg_rdata_i,
  output logic              mode_idx_stb_o,
  output logic [3:0]        mode_idx_o,
  output logic              mode_dat_stb_o,
  output logic              mode_dat_we_o,
  output logic [15:0]       mode_wdata_o,
  input  logic [15:0]       mode_rdata_i,
  output logic              big_endian_o,
  output logic [7:0]        rev_id_o
);
  region_e           region;
  logic [ADDR_W-1:0] off;
  logic              leg_done, mode_done;
  logic [DATA_W-1:0] leg_rd, mode_rd, ext_rd, sel_rd;

  assign rev_id_o = EXT_EN ? 8'd2 : BASE_REV;

  disp_mmio_decode #(.EXT_EN(EXT_EN)) u_dec (
    .addr_i   (addr_i),
    .region_o (region),
    .off_o    (off)
  );

  disp_mmio_legacy u_leg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (req_i && region == RG_LEG),
    .we_i         (we_i),
    .off_i        (off[LOFF_W-1:0]),
    .size_i       (size_i),
    .wdata_i      (wdata_i),
    .port_rdata_i (leg_rdata_i),
    .stb_o        (leg_stb_o),
    .we_o         (leg_we_o),
    .port_o       (leg_port_o),
    .port_wdata_o (leg_wdata_o),
    .done_o       (leg_done),
    .rdata_o      (leg_rd)
  );

  disp_mmio_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (req_i && region == RG_MODE),
    .we_i        (we_i),
    .off_i       (off[LOFF_W-1:0]),
    .wdata_i     (wdata_i),
    .dat_rdata_i (mode_rdata_i),
    .idx_stb_o   (mode_idx_stb_o),
    .idx_o       (mode_idx_o),
    .dat_stb_o   (mode_dat_stb_o),
    .dat_we_o    (mode_dat_we_o),
    .dat_wdata_o (mode_wdata_o),
    .done_o      (mode_done),
    .rdata_o     (mode_rd)
  );

  generate
    if (EXT_EN) begin : g_ext
      disp_mmio_ext u_ext (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .act_i        (req_i && region == RG_EXT),
        .we_i         (we_i),
        .off_i        (off[EOFF_W-1:0]),
        .size_i       (size_i),
        .wdata_i      (wdata_i),
        .big_endian_o (big_endian_o),
        .rdata_o      (ext_rd)
      );
    end else begin : g_no_ext
      assign big_endian_o = 1'b0;
      assign ext_rd       = '0;
    end
  endgenerate

  always_comb begin
    case (region)
      RG_LEG:  begin ready_o = leg_done;  sel_rd = leg_rd;  end
      RG_MODE: begin ready_o = mode_done; sel_rd = mode_rd; end
      RG_EXT:  begin ready_o = req_i;     sel_rd = ext_rd;  end
      default: begin ready_o = req_i;     sel_rd = '0;      end
    endcase
    rdata_o = ready_o ? sel_rd : '0;
  end
endmodule

// File: rtl/disp_mmio_checker.sv
module disp_mmio_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic       ready_o,
  input logic       leg_stb_o,
  input logic       leg_we_o,
  input logic [9:0] leg_port_o,
  input logic       mode_idx_stb_o,
  input logic       mode_dat_stb_o,
  input logic       big_endian_o
);
  assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({leg_stb_o, mode_idx_stb_o, mode_dat_stb_o}));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(leg_stb_o || mode_idx_stb_o || mode_dat_stb_o));

  assert_split_next_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_stb_o && !ready_o && req_i) |=> (leg_stb_o && leg_port_o == $past(leg_port_o) + 10'd1));

  assert_data_after_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_dat_stb_o |-> $past(mode_idx_stb_o));

  assert_index_then_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_idx_stb_o |-> !ready_o);

  assert_order_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(big_endian_o) |-> $past(req_i && we_i));

  assert_leg_we_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_we_o |-> (leg_stb_o && we_i));
endmodule

bind disp_mmio_window disp_mmio_checker u_chk (.*);

// File: tb/sim_disp_mmio_window.sv
`timescale 1ns/1ps
module sim_disp_mmio_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ready, u1_ready;
  logic [31:0] rdata, u1_rdata;
  logic        leg_stb, leg_we, u1_leg_stb, u1_leg_we;
  logic [9:0]  leg_port, u1_leg_port;
  logic [7:0]  leg_wdata, leg_rdata, u1_leg_wdata;
  logic        m_istb, m_dstb, m_dwe, u1_m_istb, u1_m_dstb, u1_m_dwe;
  logic [3:0]  m_idx, u1_m_idx;
  logic [15:0] m_wdata, m_rdata, u1_m_wdata;
  logic        big_e, u1_big_e;
  logic [7:0]  rev, u1_rev;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  disp_mmio_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .leg_stb_o(leg_stb), .leg_we_o(leg_we), .leg_port_o(leg_port),
    .leg_wdata_o(leg_wdata), .leg_rdata_i(leg_rdata),
    .mode_idx_stb_o(m_istb), .mode_idx_o(m_idx), .mode_dat_stb_o(m_dstb),
    .mode_dat_we_o(m_dwe), .mode_wdata_o(m_wdata), .mode_rdata_i(m_rdata),
    .big_endian_o(big_e), .rev_id_o(rev)
  );

  disp_mmio_window #(.EXT_EN(1'b0), .BASE_REV(8'h01)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ready_o(u1_ready), .rdata_o(u1_rdata),
    .leg_stb_o(u1_leg_stb), .leg_we_o(u1_leg_we), .leg_port_o(u1_leg_port),
    .leg_wdata_o(u1_leg_wdata), .leg_rdata_i(8'h00),
    .mode_idx_stb_o(u1_m_istb), .mode_idx_o(u1_m_idx), .mode_dat_stb_o(u1_m_dstb),
    .mode_dat_we_o(u1_m_dwe), .mode_wdata_o(u1_m_wdata), .mode_rdata_i(16'h0000),
    .big_endian_o(u1_big_e), .rev_id_o(u1_rev)
  );

  // downstream models
  logic [7:0]  lport [32];
  logic [15:0] mreg  [16];
  logic [3:0]  mlat = '0;
  assign leg_rdata = lport[leg_port[4:0]];
  assign m_rdata   = mreg[mlat];

  int         log_n = 0, strobes = 0, multi = 0;
  logic [9:0] log_port [16];
  logic [7:0] log_dat  [16];
  logic [3:0] last_idx = '0;

  always @(posedge clk) begin
    if (leg_stb && leg_we) lport[leg_port[4:0]] <= leg_wdata;
    if (m_istb) begin mlat <= m_idx; last_idx <= m_idx; end
    if (m_dstb && m_dwe) mreg[mlat] <= m_wdata;
    if (leg_stb) begin
      if (log_n < 16) begin log_port[log_n] <= leg_port; log_dat[log_n] <= leg_wdata; end
      log_n <= log_n + 1;
    end
    if (leg_stb || m_istb || m_dstb) strobes <= strobes + 1;
    if (32'(leg_stb) + 32'(m_istb) + 32'(m_dstb) > 1) multi <= multi + 1;
  end

  logic [7:0] exp_l [32];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // starts at a negedge, ends at the negedge after completion with req still high
  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output int cyc);
    req = 1'b1; we = w; addr = a; size = s; wdata = d; cyc = 0; rd = '0;
    forever begin
      #1;
      cyc++;
      if (ready) begin rd = rdata; @(negedge clk); break; end
      if (cyc > 16) begin check("watchdog_access", 32'(cyc), 32'd0); @(negedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    req = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int o);
    return 8'((o * 7 + 8'h31) & 8'hFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R8 reset order flag", 32'(big_e), 32'd0);
    check("R11 rev enabled", 32'(rev), 32'd2);
    check("R11 rev disabled", 32'(u1_rev), 32'h01);
    check("R1 idle ready", 32'(ready), 32'd0);

    // R2 byte writes and reads over the full legacy bank
    for (int o = 0; o < 32; o++) begin
      log_n = 0;
      access(1'b1, 12'h400 + 12'(o), 2'd0, {24'hEEEEEE, pat(o)}, rd, cyc);
      idle();
      exp_l[o] = pat(o);
      check("R2 byte write cycles", 32'(cyc), 32'd1);
      check("R2 byte write port", 32'(log_port[0]), 32'h3C0 + 32'(o));
      check("R2 byte write data", 32'(log_dat[0]), 32'(pat(o)));
    end
    for (int o = 0; o < 32; o++) begin
      access(1'b0, 12'h400 + 12'(o), 2'd0, 32'h0, rd, cyc);
      idle();
      check("R2 byte read", rd, 32'(exp_l[o]));
      check("R2 byte read cycles", 32'(cyc), 32'd1);
    end

    // R3 split 16-bit writes, low byte first
    for (int o = 0; o < 31; o += 2) begin
      logic [15:0] v;
      v = {8'(o) ^ 8'h55, 8'(o) + 8'h11};
      log_n = 0;
      access(1'b1, 12'h400 + 12'(o), 2'd1, {16'hDEAD, v}, rd, cyc);
      idle();
      exp_l[o] = v[7:0]; exp_l[o+1] = v[15:8];
      check("R3 split cycles", 32'(cyc), 32'd2);
      check("R3 first port", 32'(log_port[0]), 32'h3C0 + 32'(o));
      check("R3 first byte", 32'(log_dat[0]), 32'(v[7:0]));
      check("R3 second port", 32'(log_port[1]), 32'h3C1 + 32'(o));
      check("R3 second byte", 32'(log_dat[1]), 32'(v[15:8]));
    end

    // R4 16-bit reads, including odd start offsets
    for (int o = 0; o < 31; o++) begin
      access(1'b0, 12'h400 + 12'(o), 2'd1, 32'h0, rd, cyc);
      idle();
      check("R4 word read", rd, {16'h0, exp_l[o+1], exp_l[o]});
      check("R4 word read cycles", 32'(cyc), 32'd2);
    end

    // R5 4-byte write then 4-byte reads
    log_n = 0;
    access(1'b1, 12'h408, 2'd2, 32'h4433_2211, rd, cyc);
    idle();
    exp_l[8] = 8'h11; exp_l[9] = 8'h22; exp_l[10] = 8'h33; exp_l[11] = 8'h44;
    check("R5 dword cycles", 32'(cyc), 32'd4);
    for (int b = 0; b < 4; b++) begin
      check("R5 dword port order", 32'(log_port[b]), 32'h3C8 + 32'(b));
      check("R5 dword lane", 32'(log_dat[b]), 32'h11 * 32'(b + 1));
    end
    for (int o = 0; o < 29; o += 4) begin
      access(1'b0, 12'h400 + 12'(o), 2'd3, 32'h0, rd, cyc);
      idle();
      check("R5 dword read", rd, {exp_l[o+3], exp_l[o+2], exp_l[o+1], exp_l[o]});
      check("R5 dword read cycles", 32'(cyc), 32'd4);
    end

    // R6 mode registers: index then data
    for (int i = 0; i < 11; i++) begin
      access(1'b1, 12'h500 + 12'(2 * i), 2'd1, 32'(16'h1000 + 16'(i * 16'h0111)), rd, cyc);
      idle();
      check("R6 mode write cycles", 32'(cyc), 32'd2);
      check("R6 mode index", 32'(last_idx), 32'(i));
    end
    for (int i = 0; i < 11; i++) begin
      access(1'b0, 12'h500 + 12'(2 * i) + 12'(i & 1), 2'd1, 32'h0, rd, cyc);
      idle();
      check("R6 mode read", rd, 32'(16'h1000 + 16'(i * 16'h0111)));
      check("R6 mode read cycles", 32'(cyc), 32'd2);
    end

    // R7 / R8 extended bank reads
    access(1'b0, 12'h600, 2'd2, 32'h0, rd, cyc); idle();
    check("R7 size register", rd, 32'd8);
    check("R7 one cycle", 32'(cyc), 32'd1);
    access(1'b0, 12'h602, 2'd2, 32'h0, rd, cyc); idle();
    check("R7 undefined offset", rd, 32'd0);
    access(1'b0, 12'h606, 2'd2, 32'h0, rd, cyc); idle();
    check("R7 undefined offset high", rd, 32'd0);
    access(1'b0, 12'h604, 2'd2, 32'h0, rd, cyc); idle();
    check("R8 little pattern", rd, 32'h1E1E_1E1E);

    // R9 magic writes
    access(1'b1, 12'h604, 2'd2, 32'hBEBE_BEBE, rd, cyc); idle();
    check("R9 big selected", 32'(big_e), 32'd1);
    access(1'b0, 12'h604, 2'd2, 32'h0, rd, cyc); idle();
    check("R8 big pattern", rd, 32'hBEBE_BEBE);
    access(1'b1, 12'h604, 2'd2, 32'h1234_5678, rd, cyc); idle();
    check("R9 other value ignored", 32'(big_e), 32'd1);
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1F, rd, cyc); idle();
    check("R9 near miss ignored", 32'(big_e), 32'd1);
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1E, rd, cyc); idle();
    check("R9 little selected", 32'(big_e), 32'd0);
    access(1'b1, 12'h600, 2'd2, 32'hBEBE_BEBE, rd, cyc); idle();
    check("R9 write to size reg ignored", 32'(big_e), 32'd0);

    // R10 narrow extended accesses
    access(1'b1, 12'h604, 2'd1, 32'hBEBE_BEBE, rd, cyc); idle();
    check("R10 narrow write ignored", 32'(big_e), 32'd0);
    access(1'b1, 12'h604, 2'd0, 32'hBEBE_BEBE, rd, cyc); idle();
    check("R10 byte write ignored", 32'(big_e), 32'd0);
    access(1'b0, 12'h600, 2'd0, 32'h0, rd, cyc); idle();
    check("R10 narrow read zero", rd, 32'd0);
    access(1'b0, 12'h604, 2'd1, 32'h0, rd, cyc); idle();
    check("R10 half read zero", rd, 32'd0);

    // R1 outside all banks
    foreach (exp_l[k]) begin end
    for (int j = 0; j < 8; j++) begin
      logic [11:0] a;
      case (j)
        0: a = 12'h000; 1: a = 12'h3FF; 2: a = 12'h420; 3: a = 12'h4FF;
        4: a = 12'h516; 5: a = 12'h5FF; 6: a = 12'h608; default: a = 12'hFFF;
      endcase
      s0 = strobes;
      access(1'b1, a, 2'd2, 32'hFFFF_FFFF, rd, cyc); idle();
      check("R1 write one cycle", 32'(cyc), 32'd1);
      access(1'b0, a, 2'd2, 32'h0, rd, cyc); idle();
      check("R1 read zero", rd, 32'd0);
      check("R1 no strobe", 32'(strobes - s0), 32'd0);
    end
    access(1'b0, 12'h404, 2'd2, 32'h0, rd, cyc); idle();
    check("R1 legacy untouched", rd, {exp_l[7], exp_l[6], exp_l[5], exp_l[4]});

    // R11 bank absent when disabled
    req = 1'b1; we = 1'b0; addr = 12'h604; size = 2'd2; wdata = '0;
    #1;
    check("R11 disabled ready", 32'(u1_ready), 32'd1);
    check("R11 disabled read zero", u1_rdata, 32'd0);
    check("R11 enabled read", rdata, 32'h1E1E_1E1E);
    @(negedge clk);
    we = 1'b1; wdata = 32'hBEBE_BEBE;
    #1;
    check("R11 disabled no strobe", 32'(u1_leg_stb | u1_m_istb | u1_m_dstb), 32'd0);
    @(negedge clk);
    check("R11 disabled flag", 32'(u1_big_e), 32'd0);
    idle();
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1E, rd, cyc); idle();

    // R12 back-to-back split writes then a mode write
    log_n = 0;
    access(1'b1, 12'h410, 2'd1, 32'h0000_B2A1, rd, cyc);
    check("R12 first access cycles", 32'(cyc), 32'd2);
    access(1'b1, 12'h412, 2'd1, 32'h0000_D4C3, rd, cyc);
    check("R12 second access cycles", 32'(cyc), 32'd2);
    access(1'b1, 12'h508, 2'd1, 32'h0000_7E57, rd, cyc);
    check("R12 mode after legacy cycles", 32'(cyc), 32'd2);
    idle();
    check("R12 byte count", 32'(log_n), 32'd4);
    for (int b = 0; b < 4; b++) begin
      check("R12 port order", 32'(log_port[b]), 32'h3D0 + 32'(b));
      check("R12 byte order", 32'(log_dat[b]), 32'hA1 + 32'h11 * 32'(b));
    end
    check("R12 mode index", 32'(last_idx), 32'd4);
    access(1'b0, 12'h508, 2'd1, 32'h0, rd, cyc); idle();
    check("R12 mode value", rd, 32'h7E57);
    check("R12 single strobe", 32'(multi), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule